// File: doc/BRIEF.md
# ECC Event Capture and Status

This block sits beside a memory controller's read path and records the details of ECC events that the controller reports. Each event arrives as a one-cycle strobe with a type: a single-bit error that was corrected, or an error that could not be corrected. The strobe comes with the bus address, the access attributes, the identifier of the requesting master and the data word.

A control register holds a separate capture enable for each event type. When an event's type is enabled, the block loads all of its capture registers together and sets the sticky status flag for that type. The capture registers always hold the most recent enabled event. A later enabled event overwrites them, whether or not software has cleared the earlier flags. The captured address is the page address: the offset bits below the page boundary are dropped.

Software uses a simple register port. The port has a single-cycle write and a combinational read. Software reads the captures and clears flags by writing 1 to them. An interrupt output is raised while any flag is set whose interrupt enable is on. The capture registers are read-only and are not initialised at reset.

Top module: `ecc_event_log`

## Requirements
- R1: After reset the control register and both status flags read 0 and `irq` is low.
- R2: Control register at offset 0 has these fields: bit 0 enables capture of single-bit corrected events, bit 1 enables capture of non-correctable events, bit 2 is the interrupt enable for the corrected flag, and bit 3 is the interrupt enable for the non-correctable flag. It reads back what was written, and bits 31..4 read 0.
- R3: An event whose type is enabled (`evType` 0 = corrected, 1 = non-correctable) sets its flag in the status register at offset 1 (bit 0 = corrected, bit 1 = non-correctable). The flag is readable in the cycle after the strobe.
- R4: An enabled event loads its captures together, readable in the cycle after the strobe: the address at offset 2, the attributes at offset 3, the master identifier at offset 4, and the data at offsets 5 (bits 31..0) and 6 (bits 63..32). The attributes and master are zero-extended.
- R5: The captured address equals `evAddr` with bits below `PAGE_LSB` (default 5) cleared.
- R6: An event whose type is disabled changes neither the capture registers nor the flags.
- R7: A later enabled event overwrites every capture register, even while earlier flags are still set.
- R8: Flags are sticky. Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves it unchanged.
- R9: If an enabled event and a write-1 clear of the same flag occur in the same cycle, the flag ends up set.
- R10: `irq` equals (flag0 AND control bit 2) OR (flag1 AND control bit 3).
- R11: Writes to offsets 2 to 6 leave the captures unchanged. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evValid | input | 1 | One-cycle ECC event strobe |
| evType | input | 1 | 0 = corrected single-bit, 1 = non-correctable |
| evAddr | input | 32 | Bus address of the access |
| evAttr | input | 8 | Access attributes |
| evMaster | input | 4 | Requesting master identifier |
| evData | input | 64 | Data word of the access |
| regAddr | input | 3 | Register offset for read and write |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `evValid` and `evType` are known whenever reset is released. They also assume that a register write and an event never target the same capture state in a way the requirements leave open. The only overlap the block defines is a flag being both set and cleared in one cycle. The stimulus meets these assumptions by driving every input at the falling edge from known values and holding the event and write strobes for exactly one cycle. The same-cycle collision is driven on purpose only in the case that R9 defines. The capture registers hold unknown values until the first enabled event, so the stimulus starts with one enabled event before any capture is compared.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int unsigned OFF_CTRL   = 0;
  localparam int unsigned OFF_STATUS = 1;
  localparam int unsigned OFF_ADDR   = 2;
  localparam int unsigned OFF_ATTR   = 3;
  localparam int unsigned OFF_MASTER = 4;
  localparam int unsigned OFF_DATA0  = 5;

  localparam int unsigned NUM_TYPES = 2;
  localparam int unsigned CTRL_BITS = 2 * NUM_TYPES;

  typedef struct packed {
    logic capture;
  } capStrobes_t;

endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
#(
  parameter int unsigned REG_AW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evValid,
  input  logic                 evType,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic                 regWr,
  input  logic [31:0]          regWdata,
  output logic [CTRL_BITS-1:0] ctrlQ,
  output logic [NUM_TYPES-1:0] flagQ,
  output logic                 irq,
  output capStrobes_t          strobes
);

  logic                 ctrlWr;
  logic                 statusWr;
  logic [NUM_TYPES-1:0] capEn;
  logic [NUM_TYPES-1:0] irqEn;
  logic [NUM_TYPES-1:0] setMask;
  logic [NUM_TYPES-1:0] clrMask;

  assign ctrlWr   = regWr && (regAddr == REG_AW'(OFF_CTRL));
  assign statusWr = regWr && (regAddr == REG_AW'(OFF_STATUS));
  assign capEn    = ctrlQ[NUM_TYPES-1:0];
  assign irqEn    = ctrlQ[CTRL_BITS-1:NUM_TYPES];

  generate
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
      assign setMask[t] = evValid && (int'(evType) == t) && capEn[t];
      assign clrMask[t] = statusWr && regWdata[t];
    end
  endgenerate

  always_comb begin
    strobes         = '0;
    strobes.capture = |setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= regWdata[CTRL_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~clrMask) | setMask;
    end
  end

  assign irq = |(flagQ & irqEn);

endmodule

// File: rtl/ecc_log_datapath.sv
module ecc_log_datapath
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ATTR_W   = 8,
  parameter int unsigned MST_W    = 4,
  parameter int unsigned PAGE_LSB = 5,
  parameter int unsigned REG_AW   = 3
) (
  input  logic                 clk,
  input  capStrobes_t          strobes,
  input  logic [ADDR_W-1:0]    evAddr,
  input  logic [ATTR_W-1:0]    evAttr,
  input  logic [MST_W-1:0]     evMaster,
  input  logic [DATA_W-1:0]    evData,
  input  logic [CTRL_BITS-1:0] ctrlQ,
  input  logic [NUM_TYPES-1:0] flagQ,
  input  logic [REG_AW-1:0]    regAddr,
  output logic [ADDR_W-1:0]    capAddrQ,
  output logic [31:0]          regRdata
);

  localparam int unsigned DATA_WORDS = (DATA_W + 31) / 32;
  localparam int unsigned PAD_W      = DATA_WORDS * 32;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

  logic [ATTR_W-1:0] capAttrQ;
  logic [MST_W-1:0]  capMasterQ;
  logic [DATA_W-1:0] capDataQ;
  logic [PAD_W-1:0]  dataPad;
  logic [31:0]       dataWord [DATA_WORDS];

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      capAddrQ   <= evAddr & PAGE_MASK;
      capAttrQ   <= evAttr;
      capMasterQ <= evMaster;
      capDataQ   <= evData;
    end
  end

  assign dataPad = PAD_W'(capDataQ);

  generate
    for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
      assign dataWord[w] = dataPad[32*w +: 32];
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    unique case (int'(regAddr))
      OFF_CTRL:   regRdata = 32'(ctrlQ);
      OFF_STATUS: regRdata = 32'(flagQ);
      OFF_ADDR:   regRdata = 32'(capAddrQ);
      OFF_ATTR:   regRdata = 32'(capAttrQ);
      OFF_MASTER: regRdata = 32'(capMasterQ);
      default: begin
        for (int w = 0; w < DATA_WORDS; w++) begin
          if (int'(regAddr) == OFF_DATA0 + w) regRdata = dataWord[w];
        end
      end
    endcase
  end

endmodule

// File: rtl/ecc_event_log.sv
module ecc_event_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ATTR_W   = 8,
  parameter int unsigned MST_W    = 4,
  parameter int unsigned PAGE_LSB = 5,
  parameter int unsigned REG_AW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evType,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [ATTR_W-1:0] evAttr,
  input  logic [MST_W-1:0]  evMaster,
  input  logic [DATA_W-1:0] evData,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);

  capStrobes_t          strobes;
  logic [CTRL_BITS-1:0] ctrlQ;
  logic [NUM_TYPES-1:0] flagQ;
  logic [ADDR_W-1:0]    capAddrQ;

  ecc_log_ctrl #(.REG_AW(REG_AW)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evValid  (evValid),
    .evType   (evType),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regWdata (regWdata),
    .ctrlQ    (ctrlQ),
    .flagQ    (flagQ),
    .irq      (irq),
    .strobes  (strobes)
  );

  ecc_log_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ATTR_W   (ATTR_W),
    .MST_W    (MST_W),
    .PAGE_LSB (PAGE_LSB),
    .REG_AW   (REG_AW)
  ) i_datapath (
    .clk      (clk),
    .strobes  (strobes),
    .evAddr   (evAddr),
    .evAttr   (evAttr),
    .evMaster (evMaster),
    .evData   (evData),
    .ctrlQ    (ctrlQ),
    .flagQ    (flagQ),
    .regAddr  (regAddr),
    .capAddrQ (capAddrQ),
    .regRdata (regRdata)
  );

endmodule

// File: rtl/ecc_event_log_chk.sv
module ecc_event_log_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 5,
  parameter int unsigned REG_AW   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              evValid,
  input logic              evType,
  input logic [ADDR_W-1:0] evAddr,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWr,
  input logic [31:0]       regWdata,
  input logic [3:0]        ctrlQ,
  input logic [1:0]        flagQ,
  input logic [ADDR_W-1:0] capAddrQ,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

  logic enHit;
  logic statusWr;
  assign enHit    = evValid && (evType ? ctrlQ[1] : ctrlQ[0]);
  assign statusWr = regWr && (regAddr == REG_AW'(1));

  AST_ENABLED_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    enHit |=> flagQ[$past(evType)]); // R3

  AST_CAPTURED_PAGE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    enHit |=> capAddrQ == ($past(evAddr) & PAGE_MASK)); // R5

  AST_DISABLED_EVENT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !enHit && !regWr) |=> $stable(flagQ)); // R6

  AST_FLAG0_CLEARED_BY_W1C: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[0]) |-> $past(statusWr && regWdata[0])); // R8

  AST_FLAG1_CLEARED_BY_W1C: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[1]) |-> $past(statusWr && regWdata[1])); // R8

  AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b00) |-> !irq); // R10

endmodule

bind ecc_event_log ecc_event_log_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_LSB (PAGE_LSB),
  .REG_AW   (REG_AW)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evValid  (evValid),
  .evType   (evType),
  .evAddr   (evAddr),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .regWdata (regWdata),
  .ctrlQ    (ctrlQ),
  .flagQ    (flagQ),
  .capAddrQ (capAddrQ),
  .irq      (irq)
);

// File: tb/test_ecc_event_log.sv
module test_ecc_event_log;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic        evType = 1'b0;
  logic [31:0] evAddr = '0;
  logic [7:0]  evAttr = '0;
  logic [3:0]  evMaster = '0;
  logic [63:0] evData = '0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;

  logic [3:0]  expCtrl;
  logic [1:0]  expFlags;
  logic [31:0] expAddr;
  logic [7:0]  expAttr;
  logic [3:0]  expMst;
  logic [63:0] expData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_event_log i_ecc_event_log (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType),
    .evAddr(evAddr), .evAttr(evAttr), .evMaster(evMaster), .evData(evData),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    regAddr = 3'(a);
    #1;
    v = regRdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = 3'(a); regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Event on its own; optionally with a simultaneous status write.
  task automatic fire(input logic t, input logic [31:0] a, input logic [7:0] at,
                      input logic [3:0] m, input logic [63:0] d,
                      input logic doClr, input logic [1:0] clr);
    @(negedge clk);
    evValid = 1'b1; evType = t; evAddr = a; evAttr = at; evMaster = m; evData = d;
    if (doClr) begin regAddr = 3'd1; regWdata = 32'(clr); regWr = 1'b1; end
    @(negedge clk);
    evValid = 1'b0; regWr = 1'b0;
    if (doClr) expFlags = expFlags & ~clr;
    if (expCtrl[t]) begin
      expFlags[t] = 1'b1;
      expAddr = a & 32'hFFFF_FFE0;
      expAttr = at; expMst = m; expData = d;
    end
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(0, v); check({tag, " R2 ctrl"}, v, 32'(expCtrl));
    rd(1, v); check({tag, " R3 flags"}, v, 32'(expFlags));
    rd(2, v); check({tag, " R4/R5 addr"}, v, expAddr);
    rd(3, v); check({tag, " R4 attr"}, v, 32'(expAttr));
    rd(4, v); check({tag, " R4 master"}, v, 32'(expMst));
    rd(5, v); check({tag, " R4 data lo"}, v, expData[31:0]);
    rd(6, v); check({tag, " R4 data hi"}, v, expData[63:32]);
    rd(7, v); check({tag, " R11 unused"}, v, 32'h0);
    check({tag, " R10 irq"}, 32'(irq),
          32'((expFlags[0] & expCtrl[2]) | (expFlags[1] & expCtrl[3])));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    expCtrl = '0; expFlags = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 ctrl reset", v, 32'h0);
    rd(1, v); check("R1 flags reset", v, 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 upper bits read zero
    wr(0, 32'hFFFF_FFF3); expCtrl = 4'h3;
    rd(0, v); check("R2 ctrl readback", v, 32'h3);

    // first capture initialises the registers
    fire(1'b0, 32'h1234_567F, 8'hA5, 4'h9, 64'h0123_4567_89AB_CDEF, 1'b0, 2'b00);
    checkAll("init");

    // R6/R7/R10 sweep: every control value x both types, with and without prior clear
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 2; t++) begin
        for (int k = 0; k < 2; k++) begin
          wr(0, 32'(c)); expCtrl = 4'(c);
          if (k == 0) begin wr(1, 32'h3); expFlags = 2'b00; end
          fire(1'(t), 32'h9000_0000 + 32'(c * 977 + t * 131 + k * 7),
               8'(c * 16 + t * 3 + k), 4'(c + t + k),
               {32'(c * 65537), 32'hDEAD_0000 + 32'(t * 256 + k)}, 1'b0, 2'b00);
          checkAll($sformatf("sweep R6 R7 c=%0d t=%0d k=%0d", c, t, k));
        end
      end
    end

    // R8: writing 0 leaves flags; writing 1 to one bit clears only it
    wr(0, 32'h3); expCtrl = 4'h3;
    fire(1'b0, 32'h40, 8'h1, 4'h1, 64'h1, 1'b0, 2'b00);
    fire(1'b1, 32'h80, 8'h2, 4'h2, 64'h2, 1'b0, 2'b00);
    wr(1, 32'h0);
    rd(1, v); check("R8 write zero keeps", v, 32'h3);
    wr(1, 32'h1); expFlags = 2'b10;
    rd(1, v); check("R8 clear bit0 only", v, 32'h2);

    // R9: set and clear of the same flag in one cycle; set wins, other bit clears
    fire(1'b0, 32'hCAFE_F00D, 8'h33, 4'h5, 64'h55AA, 1'b1, 2'b11);
    rd(1, v); check("R9 set wins", v, 32'h1);
    checkAll("R9");

    // R11: writes to capture offsets are ignored
    for (int a = 2; a < 8; a++) wr(a, 32'hFFFF_FFFF);
    checkAll("R11 ro");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule